// File: doc/BRIEF.md
# Dual-Gain Range-Bin Merger

Two converters sample the same echo on every clock. One sits behind a high-gain path that resolves weak returns. The other sits behind a low-gain path, 24 dB lower, that survives strong returns. This block joins the two 14-bit streams into one 20-bit signed stream with a wider dynamic range. The choice of converter is made once per radar range bin and never sample by sample. The block looks at every high-gain sample of a bin. If any of them reaches the overload threshold, the whole bin is emitted from the low-gain converter. Otherwise the whole bin is emitted from the high-gain converter.

A bin is marked by a start strobe on its first valid input sample and holds `BIN_LEN` samples. Both channels of a bin are written into one half of a two-bank store. While that bin streams out of its half, the next bin fills the other half. Low-gain words are shifted left so that both paths share one scale. Each output word still carries only 14 significant bits. A flag beside each output word says which path supplied it.

Top module: `dual_gain_merge`

## Requirements
- R1: When no high-gain sample of a bin is an overload, every output word of that bin equals the high-gain sample sign-extended to 20 bits, and gain_sel_o is 0.
- R2: When a bin is overloaded, every output word of that bin equals the low-gain sample sign-extended and multiplied by 16 (shift of 4), so its low 4 bits are zero, and gain_sel_o is 1.
- R3: A high-gain sample is an overload when it is at least +8191 or at most -8192 (threshold magnitude parameter, default 8191). A single overload anywhere in the bin selects the low path for the whole bin. The values +8190 and -8191 do not count as overloads.
- R4: gain_sel_o holds one value for every word of a bin.
- R5: A bin leaves the block as BIN_LEN words on consecutive cycles, with bin_start_o high on the first word only. With gap-free input, each word appears BIN_LEN+1 clock edges after the edge that captured its input sample.
- R6: A bin start that arrives before the current bin is complete throws away the partial bin. That partial bin never appears at the output, and its overloads do not affect the new bin.
- R7: Input cycles are ignored when valid_i is low, including any start strobe or overload value they carry. Valid samples are also ignored before the first start and after a bin is complete until the next start.
- R8: After reset, every output is 0. No word is valid until a complete bin has been captured.
- R9: Whenever valid_o is low, data_o, gain_sel_o and bin_start_o are 0.
- R10: Back-to-back bins leave the block with no idle cycle between them, because capture of one bin overlaps readout of the previous bin. Each bin carries its own gain_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Both channel samples are valid this cycle |
| bin_start_i | input | 1 | First sample of a range bin |
| hi_i | input | 14 | High-gain channel sample, two's complement |
| lo_i | input | 14 | Low-gain channel sample, two's complement |
| valid_o | output | 1 | Output word valid |
| bin_start_o | output | 1 | First word of an output bin |
| gain_sel_o | output | 1 | 0 = high-gain source, 1 = low-gain source |
| data_o | output | 20 | Merged sample, two's complement |

## Verification
Suppose the overload flag of a bin is cleared or set wrongly. The error shows up one bin later, across all BIN_LEN words of the wrong bin, both in gain_sel_o and in the scale of data_o. Bank-swap or index faults show up as words from the previous bin, or as a shifted order, as soon as the next bin streams out. Latency and framing faults move the first valid word or the bin_start_o pulse away from its expected edge. The directed bins therefore check word values, flag, framing and cycle position together.

// File: rtl/dgm_pkg.sv
package dgm_pkg;
  typedef enum logic {
    PATH_HI = 1'b0,
    PATH_LO = 1'b1
  } path_e;
endpackage

// File: rtl/dgm_ovl_scan.sv
// Frames input bins, produces write addresses and the per-bin overload verdict.
module dgm_ovl_scan #(
  parameter int IN_W    = 14,
  parameter int BIN_LEN = 100,
  parameter int OVL_THR = 8191,
  localparam int IDX_W  = (BIN_LEN > 1) ? $clog2(BIN_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             start_i,
  input  logic [IN_W-1:0]  hi_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             done_o,
  output logic             ovl_o
);
  logic             active_q, ovl_q;
  logic [IDX_W-1:0] idx_q, idx_cur;
  logic             hit, take, last, ovl_cur;
  int               hs;

  always_comb begin
    hs      = int'($signed(hi_i));
    hit     = (hs >= OVL_THR) || (hs <= -OVL_THR - 1);
    take    = valid_i && (start_i || active_q);
    idx_cur = start_i ? '0 : idx_q;
    ovl_cur = (start_i ? 1'b0 : ovl_q) | hit;
    last    = take && (idx_cur == IDX_W'(BIN_LEN - 1));
  end

  assign wr_en_o  = take;
  assign wr_idx_o = idx_cur;
  assign done_o   = last;
  assign ovl_o    = ovl_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      ovl_q    <= 1'b0;
    end else if (take) begin
      if (last) begin
        active_q <= 1'b0;
        idx_q    <= '0;
        ovl_q    <= 1'b0;
      end else begin
        active_q <= 1'b1;
        idx_q    <= idx_cur + IDX_W'(1);
        ovl_q    <= ovl_cur;
      end
    end
  end
endmodule

// File: rtl/dgm_pingpong.sv
// Two-bank bin store: one bank fills while the other streams out.
module dgm_pingpong #(
  parameter int W      = 28,
  parameter int DEPTH  = 100,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             swap_i,
  input  logic             sel_i,
  output logic             rd_valid_o,
  output logic             rd_first_o,
  output logic             rd_sel_o,
  output logic [W-1:0]     rd_data_o
);
  import dgm_pkg::*;

  logic [W-1:0]     mem [0:1][0:DEPTH-1];
  logic             wr_bank, rd_bank, rd_run;
  logic [IDX_W-1:0] rd_idx;
  path_e            sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++)
          mem[b][i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_bank][wr_idx_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      rd_run  <= 1'b0;
      rd_idx  <= '0;
      sel_q   <= PATH_HI;
    end else if (swap_i) begin
      rd_bank <= wr_bank;
      wr_bank <= ~wr_bank;
      rd_run  <= 1'b1;
      rd_idx  <= '0;
      sel_q   <= sel_i ? PATH_LO : PATH_HI;
    end else if (rd_run) begin
      rd_idx <= rd_idx + IDX_W'(1);
      if (rd_idx == IDX_W'(DEPTH - 1)) rd_run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_first_o <= 1'b0;
      rd_sel_o   <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_run;
      rd_first_o <= rd_run && (rd_idx == '0);
      rd_sel_o   <= (sel_q == PATH_LO);
      rd_data_o  <= mem[rd_bank][rd_idx];
    end
  end
endmodule

// File: rtl/dgm_rescale.sv
// Picks the bin's source channel and aligns it to the common output scale.
module dgm_rescale #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 20,
  parameter int SHIFT = 4,
  localparam int PAD  = OUT_W - IN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              first_i,
  input  logic              sel_i,
  input  logic [IN_W-1:0]   hi_i,
  input  logic [IN_W-1:0]   lo_i,
  output logic              valid_o,
  output logic              first_o,
  output logic              sel_o,
  output logic [OUT_W-1:0]  data_o
);
  logic [OUT_W-1:0] hi_ext, lo_ext, word;

  always_comb begin
    hi_ext = {{PAD{hi_i[IN_W-1]}}, hi_i};
    lo_ext = {{PAD{lo_i[IN_W-1]}}, lo_i} << SHIFT;
    word   = sel_i ? lo_ext : hi_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      first_o <= 1'b0;
      sel_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      first_o <= valid_i && first_i;
      sel_o   <= valid_i && sel_i;
      data_o  <= valid_i ? word : '0;
    end
  end
endmodule

// File: rtl/dual_gain_merge.sv
module dual_gain_merge #(
  parameter int IN_W    = 14,
  parameter int OUT_W   = 20,
  parameter int SHIFT   = 4,
  parameter int BIN_LEN = 100,
  parameter int OVL_THR = (1 << (IN_W - 1)) - 1,
  localparam int IDX_W  = (BIN_LEN > 1) ? $clog2(BIN_LEN) : 1,
  localparam int PAIR_W = 2 * IN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             bin_start_i,
  input  logic [IN_W-1:0]  hi_i,
  input  logic [IN_W-1:0]  lo_i,
  output logic             valid_o,
  output logic             bin_start_o,
  output logic             gain_sel_o,
  output logic [OUT_W-1:0] data_o
);
  logic              wr_en, done, ovl;
  logic [IDX_W-1:0]  wr_idx;
  logic              rd_valid, rd_first, rd_sel;
  logic [PAIR_W-1:0] rd_pair;

  dgm_ovl_scan #(
    .IN_W(IN_W), .BIN_LEN(BIN_LEN), .OVL_THR(OVL_THR)
  ) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(valid_i), .start_i(bin_start_i), .hi_i(hi_i),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .done_o(done), .ovl_o(ovl)
  );

  dgm_pingpong #(
    .W(PAIR_W), .DEPTH(BIN_LEN)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i({hi_i, lo_i}),
    .swap_i(done), .sel_i(ovl),
    .rd_valid_o(rd_valid), .rd_first_o(rd_first), .rd_sel_o(rd_sel),
    .rd_data_o(rd_pair)
  );

  dgm_rescale #(
    .IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT)
  ) u_scale (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(rd_valid), .first_i(rd_first), .sel_i(rd_sel),
    .hi_i(rd_pair[PAIR_W-1:IN_W]), .lo_i(rd_pair[IN_W-1:0]),
    .valid_o(valid_o), .first_o(bin_start_o), .sel_o(gain_sel_o),
    .data_o(data_o)
  );
endmodule

// File: rtl/dual_gain_merge_chk.sv
module dual_gain_merge_chk #(
  parameter int IN_W    = 14,
  parameter int OUT_W   = 20,
  parameter int SHIFT   = 4,
  parameter int BIN_LEN = 100
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_o,
  input logic             bin_start_o,
  input logic             gain_sel_o,
  input logic [OUT_W-1:0] data_o
);
  localparam int HMAX = (1 << (IN_W - 1)) - 1;

  int run_cnt, since_rst, dval;

  always_comb dval = int'($signed(data_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt   <= 0;
      since_rst <= 0;
    end else begin
      if (valid_o) run_cnt <= bin_start_o ? 1 : run_cnt + 1;
      if (since_rst < BIN_LEN + 4) since_rst <= since_rst + 1;
    end
  end

  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (data_o == '0 && !gain_sel_o && !bin_start_o));

  p_lo_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && gain_sel_o) |-> (data_o[SHIFT-1:0] == '0));

  p_hi_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !gain_sel_o) |-> (dval <= HMAX && dval >= -HMAX - 1));

  p_sel_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bin_start_o) |-> ($past(valid_o) && $stable(gain_sel_o)));

  p_bin_body_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !bin_start_o) |-> (run_cnt >= 1 && run_cnt < BIN_LEN));

  p_bin_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && $past(valid_o)) |-> (run_cnt == BIN_LEN));

  p_first_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (since_rst >= BIN_LEN));
endmodule

bind dual_gain_merge dual_gain_merge_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .BIN_LEN(BIN_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_o(valid_o),
  .bin_start_o(bin_start_o), .gain_sel_o(gain_sel_o), .data_o(data_o)
);

// File: tb/dual_gain_merge_test.sv
`timescale 1ns/1ps
module dual_gain_merge_test;
  localparam int BL = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, bin_start_i = 1'b0;
  logic [13:0] hi_i = '0, lo_i = '0;
  logic        valid_o, bin_start_o, gain_sel_o;
  logic [19:0] data_o;

  int total = 0, bad = 0, cyc = 0, in_c0 = 0;
  int bhi [4][BL];
  int blo [4][BL];
  int cap_d[$], cap_c[$];
  bit cap_s[$], cap_st[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_gain_merge #(.BIN_LEN(BL)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .bin_start_i(bin_start_i),
    .hi_i(hi_i), .lo_i(lo_i), .valid_o(valid_o), .bin_start_o(bin_start_o),
    .gain_sel_o(gain_sel_o), .data_o(data_o)
  );

  always @(negedge clk) if (valid_o) begin
    cap_d.push_back(int'($signed(data_o)));
    cap_s.push_back(gain_sel_o);
    cap_st.push_back(bin_start_o);
    cap_c.push_back(cyc);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_w(input int h, input int l, input bit s);
    return s ? l * 16 : h;
  endfunction

  task automatic fill(input int b, input int seed, input int pos, input int val);
    for (int i = 0; i < BL; i++) begin
      bhi[b][i] = ((seed * 37 + i * 1013) % 16000) - 8000;
      blo[b][i] = ((seed * 53 + i * 2111) % 16000) - 8000;
    end
    if (pos >= 0) bhi[b][pos] = val;
  endtask

  task automatic clear_cap();
    cap_d.delete(); cap_s.delete(); cap_st.delete(); cap_c.delete();
  endtask

  task automatic drive_bin(input int b, input bit gaps);
    for (int i = 0; i < BL; i++) begin
      valid_i = 1'b1; bin_start_i = (i == 0);
      hi_i = 14'(bhi[b][i]); lo_i = 14'(blo[b][i]);
      if (i == 0) in_c0 = cyc;
      @(negedge clk);
      if (gaps) begin
        valid_i = 1'b0; bin_start_i = 1'b1; hi_i = 14'h1fff;
        @(negedge clk);
      end
    end
    valid_i = 1'b0; bin_start_i = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check_bin(input int base, input int b, input bit es, input string req,
                           input bit lat);
    if (cap_d.size() < base + BL) begin
      chk(1'b0, {req, " words"}, cap_d.size(), base + BL);
      return;
    end
    for (int i = 0; i < BL; i++) begin
      chk(cap_d[base+i] == exp_w(bhi[b][i], blo[b][i], es), req,
          cap_d[base+i], exp_w(bhi[b][i], blo[b][i], es));
      chk(cap_s[base+i] == es, {req, " R4 sel"}, cap_s[base+i], es);
      chk(cap_st[base+i] == (i == 0), "R5 start", cap_st[base+i], i == 0);
      if (i > 0) chk(cap_c[base+i] == cap_c[base+i-1] + 1, "R5 consecutive",
                     cap_c[base+i], cap_c[base+i-1] + 1);
    end
    if (lat) chk(cap_c[base] == in_c0 + BL + 2, "R5 latency", cap_c[base], in_c0 + BL + 2);
  endtask

  task automatic t_reset();
    chk(!valid_o && data_o == 0 && !gain_sel_o && !bin_start_o, "R8 reset outputs",
        int'(data_o), 0);
    clear_cap();
    for (int i = 0; i < 2 * BL; i++) begin
      valid_i = 1'b1; bin_start_i = 1'b0; hi_i = 14'(i * 100); lo_i = 14'(i);
      @(negedge clk);
    end
    valid_i = 1'b0;
    settle(BL + 4);
    chk(cap_d.size() == 0, "R7 R8 no start no output", cap_d.size(), 0);
  endtask

  task automatic t_hi_bin();
    clear_cap();
    fill(0, 3, 2, 8190);
    bhi[0][5] = -8191;
    drive_bin(0, 1'b0);
    settle(BL + 4);
    chk(cap_d.size() == BL, "R1 count", cap_d.size(), BL);
    check_bin(0, 0, 1'b0, "R1 R3 near-limit hi path", 1'b1);
  endtask

  task automatic t_ovl(input int pos, input int val, input string req);
    clear_cap();
    fill(1, 11, pos, val);
    blo[1][0] = -8192; blo[1][1] = 8191;
    drive_bin(1, 1'b0);
    settle(BL + 4);
    check_bin(0, 1, 1'b1, req, 1'b1);
  endtask

  task automatic t_back2back();
    clear_cap();
    fill(0, 5, -1, 0);
    fill(1, 7, 3, 9000 - 17192);
    fill(2, 9, -1, 0);
    drive_bin(0, 1'b0);
    drive_bin(1, 1'b0);
    drive_bin(2, 1'b0);
    settle(BL + 4);
    chk(cap_d.size() == 3 * BL, "R10 word count", cap_d.size(), 3 * BL);
    check_bin(0, 0, 1'b0, "R10 bin0 hi", 1'b0);
    check_bin(BL, 1, 1'b1, "R10 bin1 lo", 1'b0);
    check_bin(2 * BL, 2, 1'b0, "R10 bin2 hi", 1'b1);
    if (cap_c.size() == 3 * BL)
      chk(cap_c[3*BL-1] - cap_c[0] == 3 * BL - 1, "R10 no gap",
          cap_c[3*BL-1] - cap_c[0], 3 * BL - 1);
  endtask

  task automatic t_restart();
    clear_cap();
    for (int i = 0; i < 3; i++) begin
      valid_i = 1'b1; bin_start_i = (i == 0);
      hi_i = (i == 1) ? 14'h1fff : 14'(i); lo_i = 14'(i);
      @(negedge clk);
    end
    fill(3, 13, -1, 0);
    drive_bin(3, 1'b0);
    settle(BL + 4);
    chk(cap_d.size() == BL, "R6 partial bin dropped", cap_d.size(), BL);
    check_bin(0, 3, 1'b0, "R6 restart clean", 1'b1);
  endtask

  task automatic t_gaps();
    clear_cap();
    fill(2, 17, -1, 0);
    drive_bin(2, 1'b1);
    for (int i = 0; i < BL; i++) begin
      valid_i = 1'b1; bin_start_i = 1'b0; hi_i = 14'h2000; lo_i = 14'h0;
      @(negedge clk);
    end
    valid_i = 1'b0;
    settle(BL + 4);
    chk(cap_d.size() == BL, "R7 extra samples ignored", cap_d.size(), BL);
    check_bin(0, 2, 1'b0, "R7 gaps ignored", 1'b0);
    chk(!valid_o && data_o == 0 && !gain_sel_o && !bin_start_o, "R9 idle outputs",
        int'(data_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi_bin();
    t_ovl(4, 8191, "R2 R3 positive overload");
    t_ovl(BL - 1, -8192, "R2 R3 negative overload");
    t_back2back();
    t_restart();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 50000);
    total++; bad++;
    $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule